// File: doc/BRIEF.md
# E1 Receive Channel Timing Generator

This block turns an already-aligned E1 receive stream into per-channel timing. It counts bit clocks at 2.048 Mbit/s through eight bits per channel, 32 channels per frame and 16 frames per multiframe. From that position it produces four strobes: a strobe on each channel's least significant bit, a per-channel block level taken from a 32-bit mask, a one-clock boundary sync pulse, and a link-data enable for the spare national bits of timeslot 0. Downstream logic uses the strobes to gate clocks, to pick out channels and to serialise or deserialise channel data.

An upstream framer supplies the alignment. It pulses an alignment input, and the counters restart from bit 0 of channel 0 of frame 0. Between pulses the counters wrap freely. The block does not search for framing patterns. It does not check CRC-4. It has no elastic store. Every output is a flop that changes on the rising bit-clock edge, and all outputs describe the same position, which is also brought out as bit, channel and frame numbers.

Top module: `e1_rx_chan_timer`

## Requirements
- R1: Out of reset, `bit_o` (0 to 7) steps by one on every clock. `chan_o` steps when `bit_o` leaves 7 and wraps from 31 to 0. `frame_o` steps when `chan_o` wraps and wraps from 15 to 0.
- R2: When `align_i` is high at a clock edge, the position after that edge is bit 0, channel 0, frame 0, wherever the counters stood.
- R3: `chclk_o` is high exactly while `bit_o` is 7, the last and least significant bit of each channel.
- R4: `chblk_o` equals bit `chan_o` of the captured mask. Mask bit i belongs to channel i.
- R5: The mask is captured from `blk_mask_i` at the edge where the position becomes bit 0 of channel 0, whether by natural wrap or by alignment. Changes to `blk_mask_i` at any other time leave `chblk_o` unchanged until the next such edge.
- R6: With `mf_sync_i` low at the edge, `sync_o` is high for one clock at bit 0 of channel 0 in every frame.
- R7: With `mf_sync_i` high at the edge, `sync_o` is high only at bit 0 of channel 0 of frame 0.
- R8: `link_en_o` is high in channel 0 of odd frames at bit index k (3 to 7) when `sa_en_i[k-3]` is high. Index 3 is Sa4 and index 7 is Sa8, so each enabled bit adds 4 kHz.
- R9: While `rst_n` is low at a clock edge, the position goes to zero, every strobe goes low and the captured mask clears.

Strobes take the control inputs (`mf_sync_i`, `sa_en_i`) sampled at the edge that moves the position to the one they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_i | input | 1 | Restart position at zero on this edge |
| blk_mask_i | input | 32 | Per-channel block level, bit i for channel i |
| mf_sync_i | input | 1 | 1: sync marks multiframes; 0: frames |
| sa_en_i | input | 5 | Sa4..Sa8 enables, bit 0 = Sa4 |
| chclk_o | output | 1 | High during each channel's last bit |
| chblk_o | output | 1 | Block level for the current channel |
| sync_o | output | 1 | One-clock frame or multiframe boundary pulse |
| link_en_o | output | 1 | High on enabled Sa-bit positions |
| bit_o | output | 3 | Bit index within channel |
| chan_o | output | 5 | Channel (timeslot) index |
| frame_o | output | 4 | Frame index within multiframe |

## Verification
Two functions can fall on one edge: the alignment restart and the natural frame wrap. Both move the position to bit 0 of channel 0, and both capture the mask. The bench provokes this by watching the position ports until bit 7 of channel 31. It then raises `align_i` and presents a new mask at that edge. The bench also aligns in the middle of a frame with a new mask. A behavioural model tracks the position as one integer and captures the mask whenever that integer lands on a frame start. It judges `chblk_o`, `sync_o` and the counters on every clock, so a lost or doubled capture, or a counter left one step off, shows up as a miscompare.

// File: rtl/e1_rx_pkg.sv
// Shared E1 receive framing constants.
// Assumes the standard 8-bit / 32-channel / 16-frame E1 structure.
package e1_rx_pkg;
    localparam int unsigned E1_BITS_PER_CH = 8;
    localparam int unsigned E1_CH_PER_FRM  = 32;
    localparam int unsigned E1_FRM_PER_MF  = 16;
    localparam int unsigned E1_SA_FIRST    = 3;   // zero-based bit index of Sa4
    localparam int unsigned E1_SA_COUNT    = 5;   // Sa4..Sa8
endpackage

// File: rtl/e1_rx_pos_cnt.sv
// Position counter: bit within channel, channel within frame, frame within
// multiframe. Exposes the current position and the next-edge position so
// that registered strobes can be decoded one edge ahead.
// Assumes alignment is already found upstream; align_i only restarts counting.
module e1_rx_pos_cnt #(
    parameter int unsigned BITS   = 8,
    parameter int unsigned CHANS  = 32,
    parameter int unsigned FRAMES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      align_i,
    output logic [$clog2(BITS)-1:0]   bit_q,
    output logic [$clog2(CHANS)-1:0]  chan_q,
    output logic [$clog2(FRAMES)-1:0] frame_q,
    output logic [$clog2(BITS)-1:0]   bit_n,
    output logic [$clog2(CHANS)-1:0]  chan_n,
    output logic [$clog2(FRAMES)-1:0] frame_n,
    output logic                      frm_start_n
);
    localparam int unsigned BW = $clog2(BITS);
    localparam int unsigned CW = $clog2(CHANS);
    localparam int unsigned FW = $clog2(FRAMES);

    logic bit_last, chan_last, frame_last;

    // Compute the position that the next edge will load.
    always_comb begin
        bit_last   = (bit_q   == BW'(BITS - 1));
        chan_last  = (chan_q  == CW'(CHANS - 1));
        frame_last = (frame_q == FW'(FRAMES - 1));
        if (align_i) begin
            bit_n   = '0;
            chan_n  = '0;
            frame_n = '0;
        end else begin
            bit_n   = bit_last ? '0 : bit_q + 1'b1;
            chan_n  = chan_q;
            frame_n = frame_q;
            if (bit_last) begin
                chan_n = chan_last ? '0 : chan_q + 1'b1;
                if (chan_last) begin
                    frame_n = frame_last ? '0 : frame_q + 1'b1;
                end
            end
        end
        frm_start_n = (bit_n == '0) && (chan_n == '0);
    end

    // Hold the current position; reset returns it to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q   <= '0;
            chan_q  <= '0;
            frame_q <= '0;
        end else begin
            bit_q   <= bit_n;
            chan_q  <= chan_n;
            frame_q <= frame_n;
        end
    end
endmodule

// File: rtl/e1_rx_mask_stage.sv
// Per-channel block mask holding stage. The mask is captured only when the
// position enters a new frame, so one frame always sees one mask. Returns
// the block level for the channel the next edge will present.
// Assumes load_i is high exactly on the edge that enters bit 0 of channel 0.
module e1_rx_mask_stage #(
    parameter int unsigned CHANS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [CHANS-1:0]         mask_i,
    input  logic [$clog2(CHANS)-1:0] sel_i,
    output logic                     level_o
);
    logic [CHANS-1:0] mask_q;
    logic [CHANS-1:0] mask_use;

    // Capture the incoming mask at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (load_i) begin
            mask_q <= mask_i;
        end
    end

    // The boundary edge itself already uses the newly captured mask.
    always_comb begin
        mask_use = load_i ? mask_i : mask_q;
        level_o  = mask_use[sel_i];
    end
endmodule

// File: rtl/e1_rx_strobe_gen.sv
// Registered strobe decoder. Decodes the next-edge position into the
// channel-LSB strobe, block level, boundary sync and Sa-bit link enable,
// and registers them so they change on the bit-clock edge together with
// the position counters.
// Assumes Sa bits live in channel 0 of odd frames at indices SA_FIRST upward.
module e1_rx_strobe_gen #(
    parameter int unsigned BITS     = 8,
    parameter int unsigned CHANS    = 32,
    parameter int unsigned FRAMES   = 16,
    parameter int unsigned SA_FIRST = 3,
    parameter int unsigned SA_COUNT = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BITS)-1:0]   bit_n,
    input  logic [$clog2(CHANS)-1:0]  chan_n,
    input  logic [$clog2(FRAMES)-1:0] frame_n,
    input  logic                      mf_sync_i,
    input  logic [SA_COUNT-1:0]       sa_en_i,
    input  logic                      blk_lvl_i,
    output logic                      chclk_o,
    output logic                      chblk_o,
    output logic                      sync_o,
    output logic                      link_en_o
);
    localparam int unsigned BW = $clog2(BITS);

    logic [SA_COUNT-1:0] sa_hit;
    logic chclk_d, sync_d, link_d, ts0_odd;

    // One comparator per Sa bit position, gated by its enable.
    for (genvar g = 0; g < SA_COUNT; g++) begin : g_sa
        assign sa_hit[g] = sa_en_i[g] && (bit_n == BW'(SA_FIRST + g));
    end

    // Decode strobes for the position the next edge presents.
    always_comb begin
        ts0_odd = (chan_n == '0) && frame_n[0];
        chclk_d = (bit_n == BW'(BITS - 1));
        sync_d  = (bit_n == '0) && (chan_n == '0) && (!mf_sync_i || (frame_n == '0));
        link_d  = ts0_odd && (|sa_hit);
    end

    // Register the strobes; reset forces them low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chclk_o   <= 1'b0;
            chblk_o   <= 1'b0;
            sync_o    <= 1'b0;
            link_en_o <= 1'b0;
        end else begin
            chclk_o   <= chclk_d;
            chblk_o   <= blk_lvl_i;
            sync_o    <= sync_d;
            link_en_o <= link_d;
        end
    end
endmodule

// File: rtl/e1_rx_chan_timer.sv
// E1 receive channel timing generator top. Ties the position counter, the
// frame-boundary mask stage and the registered strobe decoder together.
// Assumes an upstream framer has found alignment and signals it on align_i.
module e1_rx_chan_timer
    import e1_rx_pkg::*;
#(
    parameter int unsigned BITS     = E1_BITS_PER_CH,
    parameter int unsigned CHANS    = E1_CH_PER_FRM,
    parameter int unsigned FRAMES   = E1_FRM_PER_MF,
    parameter int unsigned SA_FIRST = E1_SA_FIRST,
    parameter int unsigned SA_COUNT = E1_SA_COUNT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      align_i,
    input  logic [CHANS-1:0]          blk_mask_i,
    input  logic                      mf_sync_i,
    input  logic [SA_COUNT-1:0]       sa_en_i,
    output logic                      chclk_o,
    output logic                      chblk_o,
    output logic                      sync_o,
    output logic                      link_en_o,
    output logic [$clog2(BITS)-1:0]   bit_o,
    output logic [$clog2(CHANS)-1:0]  chan_o,
    output logic [$clog2(FRAMES)-1:0] frame_o
);
    localparam int unsigned BW = $clog2(BITS);
    localparam int unsigned CW = $clog2(CHANS);
    localparam int unsigned FW = $clog2(FRAMES);

    logic [BW-1:0] bit_n;
    logic [CW-1:0] chan_n;
    logic [FW-1:0] frame_n;
    logic          frm_start_n;
    logic          blk_lvl;

    e1_rx_pos_cnt #(.BITS(BITS), .CHANS(CHANS), .FRAMES(FRAMES)) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .align_i     (align_i),
        .bit_q       (bit_o),
        .chan_q      (chan_o),
        .frame_q     (frame_o),
        .bit_n       (bit_n),
        .chan_n      (chan_n),
        .frame_n     (frame_n),
        .frm_start_n (frm_start_n)
    );

    e1_rx_mask_stage #(.CHANS(CHANS)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frm_start_n),
        .mask_i  (blk_mask_i),
        .sel_i   (chan_n),
        .level_o (blk_lvl)
    );

    e1_rx_strobe_gen #(
        .BITS(BITS), .CHANS(CHANS), .FRAMES(FRAMES),
        .SA_FIRST(SA_FIRST), .SA_COUNT(SA_COUNT)
    ) u_strb (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_n     (bit_n),
        .chan_n    (chan_n),
        .frame_n   (frame_n),
        .mf_sync_i (mf_sync_i),
        .sa_en_i   (sa_en_i),
        .blk_lvl_i (blk_lvl),
        .chclk_o   (chclk_o),
        .chblk_o   (chblk_o),
        .sync_o    (sync_o),
        .link_en_o (link_en_o)
    );
endmodule

// File: rtl/e1_rx_chan_timer_chk.sv
// Property checker for e1_rx_chan_timer, attached with bind below.
// Assumes the default 8/32/16 framing structure.
module e1_rx_chan_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       align_i,
    input logic       mf_sync_i,
    input logic       chclk_o,
    input logic       sync_o,
    input logic       link_en_o,
    input logic [2:0] bit_o,
    input logic [4:0] chan_o,
    input logic [3:0] frame_o
);
    // R1
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_i && bit_o != 3'd7) |=> (bit_o == 3'($past(bit_o) + 3'd1)));

    // R2
    align_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_i |=> (bit_o == 3'd0 && chan_o == 5'd0 && frame_o == 4'd0));

    // R3
    chclk_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chclk_o |-> (bit_o == 3'd7));

    // R3
    chclk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chclk_o, sync_o}));

    // R6
    sync_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (bit_o == 3'd0 && chan_o == 5'd0));

    // R7
    mf_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && $past(mf_sync_i)) |-> (frame_o == 4'd0));

    // R8
    link_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_en_o |-> (chan_o == 5'd0 && frame_o[0] && bit_o >= 3'd3));
endmodule

bind e1_rx_chan_timer e1_rx_chan_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .align_i   (align_i),
    .mf_sync_i (mf_sync_i),
    .chclk_o   (chclk_o),
    .sync_o    (sync_o),
    .link_en_o (link_en_o),
    .bit_o     (bit_o),
    .chan_o    (chan_o),
    .frame_o   (frame_o)
);

// File: tb/tb_e1_rx_chan_timer.sv
`timescale 1ns/1ps
module tb_e1_rx_chan_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align_i = 1'b0;
    logic [31:0] blk_mask_i = 32'h0;
    logic        mf_sync_i = 1'b0;
    logic [4:0]  sa_en_i = 5'h0;
    logic        chclk_o, chblk_o, sync_o, link_en_o;
    logic [2:0]  bit_o;
    logic [4:0]  chan_o;
    logic [3:0]  frame_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // Behavioural reference state
    int          pos = 0;
    logic [31:0] m_mask = 32'h0;
    bit          in_rst = 1;
    bit          mf_at_edge = 0;
    int          e_b = 0, e_c = 0, e_f = 0;
    bit          e_ch = 0, e_blk = 0, e_sync = 0, e_link = 0;

    always #2 clk = ~clk;

    e1_rx_chan_timer dut (
        .clk(clk), .rst_n(rst_n), .align_i(align_i), .blk_mask_i(blk_mask_i),
        .mf_sync_i(mf_sync_i), .sa_en_i(sa_en_i), .chclk_o(chclk_o),
        .chblk_o(chblk_o), .sync_o(sync_o), .link_en_o(link_en_o),
        .bit_o(bit_o), .chan_o(chan_o), .frame_o(frame_o)
    );

    // Reference model: position as a single integer over the multiframe.
    always @(posedge clk) begin
        if (!rst_n) begin
            in_rst = 1; pos = 0; m_mask = 32'h0;
            e_ch = 0; e_blk = 0; e_sync = 0; e_link = 0;
        end else begin
            in_rst = 0;
            pos = align_i ? 0 : (pos + 1) % 4096;
            if (pos % 256 == 0) m_mask = blk_mask_i;
            mf_at_edge = mf_sync_i;
            e_ch   = (pos % 8 == 7);
            e_blk  = m_mask[(pos / 8) % 32];
            e_sync = (pos % 256 == 0) && (!mf_sync_i || pos == 0);
            e_link = ((pos / 8) % 32 == 0) && ((pos / 256) % 2 == 1) && (pos % 8 >= 3)
                     && sa_en_i[(pos % 8) - 3 + ((pos % 8) < 3 ? 3 : 0)];
        end
        e_b = pos % 8; e_c = (pos / 8) % 32; e_f = pos / 256;
    end

    task automatic chk(input string req, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (in_rst) begin
                chk("R9 chclk", chclk_o, 0);  chk("R9 chblk", chblk_o, 0);
                chk("R9 sync", sync_o, 0);    chk("R9 link", link_en_o, 0);
                chk("R9 pos", {bit_o, chan_o, frame_o}, 0);
            end else begin
                chk("R1/R2 bit", bit_o, e_b);
                chk("R1/R2 chan", chan_o, e_c);
                chk("R1/R2 frame", frame_o, e_f);
                chk("R3 chclk", chclk_o, e_ch);
                chk("R4/R5 chblk", chblk_o, e_blk);
                chk(mf_at_edge ? "R7 sync" : "R6 sync", sync_o, e_sync);
                chk("R8 link", link_en_o, e_link);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_align();
        align_i = 1'b1;
        @(negedge clk);
        align_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        // R9 reset state
        blk_mask_i = 32'hA5A5_0F0F; sa_en_i = 5'b11111;
        cycles(5);
        rst_n = 1'b1;
        // R1 R3 R4 R6 free run, mask changes mid-frame (R5)
        cycles(700);
        blk_mask_i = 32'h1234_8001;
        cycles(130);
        blk_mask_i = 32'hFFFF_0000;
        cycles(600);
        // R7 multiframe sync over more than one multiframe
        mf_sync_i = 1'b1;
        cycles(4300);
        // R8 Sa enable patterns
        mf_sync_i = 1'b0;
        sa_en_i = 5'b00101;
        cycles(600);
        sa_en_i = 5'b10010;
        cycles(600);
        sa_en_i = 5'b00000;
        cycles(600);
        // R2 align mid-frame with a new mask (R5 capture on align)
        sa_en_i = 5'b11111;
        cycles(77);
        blk_mask_i = 32'h0F0F_F0F0;
        pulse_align();
        cycles(300);
        // R2 R5 align on the same edge as the natural frame wrap
        while (!(bit_o == 3'd7 && chan_o == 5'd31)) @(negedge clk);
        blk_mask_i = 32'h8000_0003;
        pulse_align();
        cycles(600);
        // R7 align in multiframe mode away from frame 0
        mf_sync_i = 1'b1;
        cycles(1000);
        pulse_align();
        cycles(4200);
        // R9 reset mid-run clears mask and position
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(600);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule